// File: doc/BRIEF.md
# Serial Clock Stall Watchdog and Pulse-Signature Reset Detector

This block watches the host serial clock from the system clock domain. It brings the serial clock in through a synchronizer and measures how long each high and low level lasts, in system clocks. From those measurements it derives two single-cycle reset requests. Neither request clears any register by itself; the surrounding logic decides what each one resets.

The first request, the interface reset, guards against a host that stops in the middle of a transaction. The serial decoder raises a "transaction open" level from the first instruction bit until the last data bit. While that level is high, a timer counts system clocks, and every serial clock edge restarts it. If the timer reaches its limit, the interface reset fires once. The host must then begin again with a fresh instruction byte, while the stored registers keep their contents.

The second request, the device reset, fires when the host holds the serial clock in a fixed three-pulse signature. Each of the three high times must fall inside its own window, and each of the two low gaps between them must also fall inside a window. The request fires on the falling edge that ends the third pulse. Ordinary serial traffic is limited to one tenth of the system clock rate, so its high times stay far below the first window and can never match the signature.

Top module: `sclk_watchdog`

## Requirements
- R1: After reset, both `if_rst_o` and `dev_rst_o` are low, and the signature detector is idle, so a partial signature sent before reset cannot complete after it.
- R2: While `xfer_open_i` is high and no serial clock edge is seen, `if_rst_o` is high during the clock cycle that follows the STALL_CLKS-th consecutive rising clock edge at which `xfer_open_i` was sampled high.
- R3: Every synchronized serial clock edge restarts the stall timer, and a low `xfer_open_i` clears it. Serial traffic that keeps toggling, or a transaction that is closed before the limit, produces no interface reset.
- R4: The interface reset is a single-cycle pulse. It does not repeat until the timer has been restarted by an edge or by closing the transaction.
- R5: A valid three-pulse signature raises `dev_rst_o` for exactly one cycle. The pulse appears SYNC_STAGES+1 system clocks after the serial clock falls at the end of the third pulse, and the detector then returns to idle.
- R6: The first high time is accepted only when it is strictly between HI1_MIN and HI1_MAX. The values HI1_MIN and HI1_MAX themselves are rejected, while HI1_MIN+1 and HI1_MAX-1 are accepted.
- R7: The third high time is accepted from HI3_MIN inclusive up to HI3_MAX exclusive. A third pulse of exactly HI3_MIN completes the signature; one of HI3_MIN-1 or HI3_MAX does not.
- R8: Each low gap must be longer than GAP_MIN and no longer than GAP_MAX. A gap outside this window abandons the signature without any reset, and the rising edge that ends the bad gap starts a new first pulse.
- R9: The second high time is accepted only when it is strictly between HI2_MIN and HI2_MAX. A rejected second pulse, and any serial traffic whose high times stay below the first window, leave `dev_rst_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock, asynchronous to `clk` |
| xfer_open_i | input | 1 | High from the first instruction bit until the last data bit of a transaction |
| if_rst_o | output | 1 | One-cycle interface reset request after a stalled transaction |
| dev_rst_o | output | 1 | One-cycle device reset request after a valid clock signature |

## Verification
The bench builds the block with a stall limit of 40 clocks. The signature windows are shrunk to 12/20, 24/36 and 40/48, with gaps bounded by 3 and 30, and the synchronizer is kept at two stages. With these values, every window boundary, both gap limits and the exact stall cycle can be reached within a few hundred clocks each. The exact latency through the synchronizer is checked as well. A table of signatures sweeps the high and gap boundaries one at a time. Directed sequences then cover reset in the middle of a signature, recovery from a bad gap, stall restart by an edge, and closing of the transaction.

// File: rtl/sclk_watchdog_pkg.sv
package sclk_watchdog_pkg;

   typedef enum logic [2:0] {
      PAT_IDLE = 3'd0,
      PAT_HI1  = 3'd1,
      PAT_LO1  = 3'd2,
      PAT_HI2  = 3'd3,
      PAT_LO2  = 3'd4,
      PAT_HI3  = 3'd5
   } pat_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      return max2(max2(a, b), max2(c, d));
   endfunction

endpackage

// File: rtl/swd_sync.sv
module swd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o,
   output logic fall_o
);

   logic level;
   logic level_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign level = async_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i};
         end
         assign level = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise_o =  level & ~level_q;
   assign fall_o = ~level &  level_q;

endmodule

// File: rtl/swd_runlen.sv
module swd_runlen #(
   parameter int unsigned RUN_SAT = 64,
   localparam int unsigned RUN_W  = $clog2(RUN_SAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_i,
   output logic [RUN_W-1:0] len_o
);

   logic [RUN_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        len_q <= '0;
      else if (edge_i)                   len_q <= RUN_W'(1);
      else if (len_q != RUN_W'(RUN_SAT)) len_q <= len_q + RUN_W'(1);
   end

   assign len_o = len_q;

   assert_len_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= RUN_W'(RUN_SAT));

endmodule

// File: rtl/swd_pattern.sv
module swd_pattern
   import sclk_watchdog_pkg::*;
#(
   parameter int unsigned HI1_MIN = 512,
   parameter int unsigned HI1_MAX = 800,
   parameter int unsigned HI2_MIN = 1024,
   parameter int unsigned HI2_MAX = 1800,
   parameter int unsigned HI3_MIN = 2048,
   parameter int unsigned HI3_MAX = 2400,
   parameter int unsigned GAP_MIN = 10,
   parameter int unsigned GAP_MAX = 4096,
   parameter int unsigned RUN_W   = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic [RUN_W-1:0] len_i,
   output logic             dev_rst_o
);

   pat_state_e state_q, state_d;
   logic       fire_d, fire_q;
   logic       hi1_ok, hi2_ok, hi3_ok, gap_ok;

   assign hi1_ok = (len_i > RUN_W'(HI1_MIN)) && (len_i < RUN_W'(HI1_MAX));
   assign hi2_ok = (len_i > RUN_W'(HI2_MIN)) && (len_i < RUN_W'(HI2_MAX));
   assign hi3_ok = (len_i >= RUN_W'(HI3_MIN)) && (len_i < RUN_W'(HI3_MAX));
   assign gap_ok = (len_i > RUN_W'(GAP_MIN)) && (len_i <= RUN_W'(GAP_MAX));

   always_comb begin
      state_d = state_q;
      fire_d  = 1'b0;
      unique case (state_q)
         PAT_IDLE: if (rise_i) state_d = PAT_HI1;
         PAT_HI1:  if (fall_i) state_d = hi1_ok ? PAT_LO1 : PAT_IDLE;
         PAT_LO1:  if (rise_i) state_d = gap_ok ? PAT_HI2 : PAT_HI1;
         PAT_HI2:  if (fall_i) state_d = hi2_ok ? PAT_LO2 : PAT_IDLE;
         PAT_LO2:  if (rise_i) state_d = gap_ok ? PAT_HI3 : PAT_HI1;
         PAT_HI3:  if (fall_i) begin
                      state_d = PAT_IDLE;
                      fire_d  = hi3_ok;
                   end
         default:  state_d = PAT_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PAT_IDLE;
         fire_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         fire_q  <= fire_d;
      end
   end

   assign dev_rst_o = fire_q;

   assert_dev_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst_o |=> !dev_rst_o);
   assert_dev_back_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst_o |-> state_q == PAT_IDLE);
   assert_dev_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst_o |-> $past(fall_i));
   assert_hi3_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst_o |-> ($past(len_i) >= RUN_W'(HI3_MIN)) && ($past(len_i) < RUN_W'(HI3_MAX)));
   assert_idle_needs_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PAT_IDLE && !rise_i) |=> state_q == PAT_IDLE);
   assert_bad_gap_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == PAT_LO1 || state_q == PAT_LO2) && rise_i && !gap_ok) |=> state_q == PAT_HI1);

endmodule

// File: rtl/swd_idle.sv
module swd_idle #(
   parameter int unsigned STALL_CLKS = 250000,
   localparam int unsigned IDL_W     = $clog2(STALL_CLKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic edge_i,
   output logic if_rst_o
);

   logic [IDL_W-1:0] cnt_q;
   logic             pulse_q;
   logic             running;

   assign running = open_i && !edge_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= running && (cnt_q == IDL_W'(STALL_CLKS - 1));
         if (!running)                          cnt_q <= '0;
         else if (cnt_q != IDL_W'(STALL_CLKS))  cnt_q <= cnt_q + IDL_W'(1);
      end
   end

   assign if_rst_o = pulse_q;

   assert_if_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      if_rst_o |=> !if_rst_o);
   assert_if_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      if_rst_o |-> cnt_q == IDL_W'(STALL_CLKS));
   assert_if_no_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == IDL_W'(STALL_CLKS) && $past(cnt_q) == IDL_W'(STALL_CLKS)) |-> !if_rst_o);
   assert_if_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      if_rst_o |-> $past(open_i));

endmodule

// File: rtl/sclk_watchdog.sv
module sclk_watchdog
   import sclk_watchdog_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STALL_CLKS  = 250000,
   parameter int unsigned HI1_MIN     = 512,
   parameter int unsigned HI1_MAX     = 800,
   parameter int unsigned HI2_MIN     = 1024,
   parameter int unsigned HI2_MAX     = 1800,
   parameter int unsigned HI3_MIN     = 2048,
   parameter int unsigned HI3_MAX     = 2400,
   parameter int unsigned GAP_MIN     = 10,
   parameter int unsigned GAP_MAX     = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic xfer_open_i,
   output logic if_rst_o,
   output logic dev_rst_o
);

   localparam int unsigned RUN_SAT = max4(HI1_MAX, HI2_MAX, HI3_MAX, GAP_MAX) + 1;
   localparam int unsigned RUN_W   = $clog2(RUN_SAT + 1);

   initial begin
      assert (SYNC_STAGES != 1) else $error("SYNC_STAGES must be 0 or at least 2");
      assert (STALL_CLKS >= 2) else $error("STALL_CLKS must be at least 2");
      assert (HI1_MIN + 1 < HI1_MAX) else $error("first high window is empty");
      assert (HI2_MIN + 1 < HI2_MAX) else $error("second high window is empty");
      assert (HI3_MIN < HI3_MAX) else $error("third high window is empty");
      assert (GAP_MIN < GAP_MAX) else $error("gap window is empty");
   end

   logic              sclk_rise, sclk_fall, sclk_edge;
   logic [RUN_W-1:0]  run_len;

   swd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sclk_i),
      .rise_o  (sclk_rise),
      .fall_o  (sclk_fall)
   );

   assign sclk_edge = sclk_rise | sclk_fall;

   swd_runlen #(.RUN_SAT(RUN_SAT)) u_runlen (
      .clk    (clk),
      .rst_n  (rst_n),
      .edge_i (sclk_edge),
      .len_o  (run_len)
   );

   swd_pattern #(
      .HI1_MIN (HI1_MIN), .HI1_MAX (HI1_MAX),
      .HI2_MIN (HI2_MIN), .HI2_MAX (HI2_MAX),
      .HI3_MIN (HI3_MIN), .HI3_MAX (HI3_MAX),
      .GAP_MIN (GAP_MIN), .GAP_MAX (GAP_MAX),
      .RUN_W   (RUN_W)
   ) u_pattern (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (sclk_rise),
      .fall_i    (sclk_fall),
      .len_i     (run_len),
      .dev_rst_o (dev_rst_o)
   );

   swd_idle #(.STALL_CLKS(STALL_CLKS)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_i   (xfer_open_i),
      .edge_i   (sclk_edge),
      .if_rst_o (if_rst_o)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !if_rst_o && !dev_rst_o);

endmodule

// File: tb/sclk_watchdog_tb.sv
module sclk_watchdog_tb;

   localparam int unsigned STALL = 40;
   localparam int unsigned H1N = 12, H1X = 20, H2N = 24, H2X = 36, H3N = 40, H3X = 48;
   localparam int unsigned GN = 3, GX = 30;

   // h1, gap1, h2, gap2, h3, expected device reset pulses
   localparam int unsigned VEC [0:11][0:5] = '{
      '{16,  8, 30,  8, 44, 1},
      '{13,  4, 25,  4, 40, 1},
      '{19, 30, 35, 30, 47, 1},
      '{12,  8, 30,  8, 44, 0},
      '{20,  8, 30,  8, 44, 0},
      '{16,  8, 24,  8, 44, 0},
      '{16,  8, 36,  8, 44, 0},
      '{16,  8, 30,  8, 48, 0},
      '{16,  8, 30,  8, 39, 0},
      '{16,  3, 30,  8, 44, 0},
      '{16, 31, 30,  8, 44, 0},
      '{16,  8, 30,  3, 44, 0}
   };
   localparam string VTAG [0:11] = '{"R5", "R6 R8", "R6 R8", "R6", "R6", "R9",
                                     "R9", "R7", "R7", "R8", "R8", "R8"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic xopen = 1'b0;
   logic if_rst, dev_rst;

   int checks = 0;
   int fails = 0;
   int if_cnt = 0;
   int dev_cnt = 0;

   always #4 clk = ~clk;

   sclk_watchdog #(
      .SYNC_STAGES(2), .STALL_CLKS(STALL),
      .HI1_MIN(H1N), .HI1_MAX(H1X), .HI2_MIN(H2N), .HI2_MAX(H2X),
      .HI3_MIN(H3N), .HI3_MAX(H3X), .GAP_MIN(GN), .GAP_MAX(GX)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .xfer_open_i(xopen),
      .if_rst_o(if_rst), .dev_rst_o(dev_rst)
   );

   always @(posedge clk) begin
      if (if_rst)  if_cnt  <= if_cnt + 1;
      if (dev_rst) dev_cnt <= dev_cnt + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic pulse(input int unsigned hi, input int unsigned lo);
      sclk = 1'b1;
      repeat (hi) @(negedge clk);
      sclk = 1'b0;
      repeat (lo) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      check("R1 if_rst in reset", int'(if_rst), 0);
      check("R1 dev_rst in reset", int'(dev_rst), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 if_rst after reset", int'(if_rst), 0);
      check("R1 dev_rst after reset", int'(dev_rst), 0);

      // R5 exact latency: pulse appears SYNC_STAGES+1 clocks after the last fall
      pulse(16, 8);
      pulse(30, 8);
      sclk = 1'b1;
      repeat (44) @(negedge clk);
      sclk = 1'b0;
      @(negedge clk); check("R5 latency t+1", int'(dev_rst), 0);
      @(negedge clk); check("R5 latency t+2", int'(dev_rst), 0);
      @(negedge clk); check("R5 latency t+3", int'(dev_rst), 1);
      @(negedge clk); check("R5 single cycle", int'(dev_rst), 0);
      repeat (10) @(negedge clk);

      // table of signatures
      for (int i = 0; i < 12; i++) begin
         base = dev_cnt;
         pulse(VEC[i][0], VEC[i][1]);
         pulse(VEC[i][2], VEC[i][3]);
         pulse(VEC[i][4], 10);
         check($sformatf("%s vector %0d", VTAG[i], i), dev_cnt - base, int'(VEC[i][5]));
      end

      // R8: bad gap, the rising edge that ends it starts a new first pulse
      base = dev_cnt;
      pulse(16, 2);
      pulse(16, 8);
      pulse(30, 8);
      pulse(44, 10);
      check("R8 restart from bad gap", dev_cnt - base, 1);

      // R1: reset in the middle of a signature abandons it
      base = dev_cnt;
      pulse(16, 8);
      pulse(30, 4);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      pulse(44, 10);
      check("R1 reset clears partial signature", dev_cnt - base, 0);

      // R2 exact stall timing, R4 single and not repeated
      base = if_cnt;
      xopen = 1'b1;
      repeat (STALL - 1) @(negedge clk);
      check("R2 before limit", int'(if_rst), 0);
      @(negedge clk);
      check("R2 at limit", int'(if_rst), 1);
      @(negedge clk);
      check("R4 single cycle", int'(if_rst), 0);
      repeat (3 * STALL) @(negedge clk);
      check("R4 no repeat", if_cnt - base, 1);
      xopen = 1'b0;
      repeat (4) @(negedge clk);

      // R3: an edge restarts the timer
      base = if_cnt;
      xopen = 1'b1;
      repeat (30) @(negedge clk);
      sclk = 1'b1;
      repeat (STALL) @(negedge clk);
      check("R3 edge restarts timer", if_cnt - base, 0);
      repeat (4) @(negedge clk);
      check("R3 pulse after restarted limit", if_cnt - base, 1);
      xopen = 1'b0;
      sclk = 1'b0;
      repeat (4) @(negedge clk);

      // R3: closing the transaction clears the timer
      base = if_cnt;
      xopen = 1'b1;
      repeat (30) @(negedge clk);
      xopen = 1'b0;
      repeat (5) @(negedge clk);
      xopen = 1'b1;
      repeat (30) @(negedge clk);
      xopen = 1'b0;
      repeat (3 * STALL) @(negedge clk);
      check("R3 closed transaction clears timer", if_cnt - base, 0);

      // R3 and R9: toggling traffic keeps the timer alive and never matches the signature
      base = if_cnt;
      begin
         int dbase;
         dbase = dev_cnt;
         xopen = 1'b1;
         for (int k = 0; k < 40; k++) pulse(5, 5);
         check("R3 toggling traffic no stall", if_cnt - base, 0);
         check("R9 toggling traffic no device reset", dev_cnt - dbase, 0);
      end
      repeat (STALL + 6) @(negedge clk);
      check("R2 stall after traffic stops", if_cnt - base, 1);
      xopen = 1'b0;
      repeat (4) @(negedge clk);

      finish_run();
   end

endmodule